// File: doc/BRIEF.md
# Long Packet Payload CRC-16

This block computes the 16-bit checksum that protects the payload of a long packet on a serial display link. It also checks that checksum against the footer a peer sends. Payload bytes arrive one per cycle on a byte strobe, with first and last markers. The running CRC is preset to all ones at the first byte and advances one whole byte per accepted cycle. Each byte is folded in starting at bit 0, using the reflected form of x^16 + x^12 + x^5 + 1, which is 0x8408. No final inversion or reflection is applied. A payload with no bytes at all is announced by a single-cycle empty strobe and yields 0xFFFF.

When a payload ends, the block drives the two footer bytes on consecutive cycles, low byte first. On the receive side, the peer's two footer bytes are presented on a separate strobe, also low byte first. After the second byte, a done pulse is raised together with an error pulse if the received word differs from the computed one. The check only detects errors; it never corrects anything. Checking can be switched off for peers that place 0x0000 in the footer because they do not compute checksums. Consecutive payload ends must be at least two cycles apart so that each footer can leave intact.

Top module: `crc16_lp_top`

## Requirements
- R1: The checksum is the CRC with reflected polynomial 0x8408 (x^16+x^12+x^5+1), processed least-significant bit of each byte first, preset 0xFFFF, no final XOR. The ASCII payload "123456789" gives 0x6F91.
- R2: A cycle with byte_valid=1 and byte_first=1 presets the CRC before folding in that byte, so every payload's checksum is independent of earlier payloads.
- R3: A pulse on empty_pkt (with byte_valid=0) ends a zero-length payload whose checksum is 0xFFFF.
- R4: In the cycle after a payload ends, ftr_valid=1, ftr_hi=0 and ftr_data carries CRC bits 7:0. In the next cycle, ftr_valid=1, ftr_hi=1 and ftr_data carries bits 15:8. After that, ftr_valid returns to 0.
- R5: While byte_valid=0, byte_first, byte_last and byte_data have no effect on the CRC.
- R6: With chk_en=1, the cycle after the second rx_valid footer byte shows chk_done=1 and crc_err=0 when {second byte, first byte} equals the computed checksum.
- R7: With chk_en=1, that same cycle shows chk_done=1 and crc_err=1 when the received footer differs from the computed checksum.
- R8: With chk_en=0, crc_err stays 0 for any received footer, including 0x0000, while chk_done still pulses.
- R9: During and right after reset, ftr_valid, chk_done and crc_err are 0.
- R10: Payloads of hundreds of bytes produce the same checksum as the bit-serial definition of R1.
- R11: The start of a payload (byte_first with byte_valid, or empty_pkt) realigns the receive footer pairing, so a stray single rx_valid byte beforehand is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Payload byte present this cycle |
| byte_first | input | 1 | Marks the first payload byte |
| byte_last | input | 1 | Marks the last payload byte |
| byte_data | input | 8 | Payload byte |
| empty_pkt | input | 1 | Single-cycle pulse for a zero-length payload |
| chk_en | input | 1 | Enables footer comparison |
| rx_valid | input | 1 | Received footer byte present |
| rx_data | input | 8 | Received footer byte, low byte first |
| ftr_valid | output | 1 | Generated footer byte valid |
| ftr_hi | output | 1 | Generated footer byte is the high byte |
| ftr_data | output | 8 | Generated footer byte |
| chk_done | output | 1 | Pulse: received footer complete |
| crc_err | output | 1 | Pulse with chk_done: footer mismatch |

## Verification
The hardest condition to reach is a receive footer sequence that has fallen out of step. This happens when one lone footer byte arrives before a new payload starts. Only the realignment at payload start prevents the next correct footer from being paired wrongly and reported as a mismatch. The stimulus injects one stray rx_valid byte, confirms that no done pulse follows it, and then sends a full payload with its correct footer. It expects done without error. A second hard case is strobe noise inside a payload. Here a gap cycle with first and last raised but byte_valid low must leave the checksum unchanged.

// File: rtl/crc16_lp_pkg.sv
package crc16_lp_pkg;

   typedef enum logic [1:0] {
      FT_IDLE = 2'd0,
      FT_LOW  = 2'd1,
      FT_HIGH = 2'd2
   } ftr_state_e;

   typedef enum logic {
      UPD_SERIAL = 1'b0,
      UPD_MATRIX = 1'b1
   } upd_style_e;

endpackage

// File: rtl/crc16_lp_step.sv
module crc16_lp_step
   import crc16_lp_pkg::*;
#(
   parameter int                 CRC_W    = 16,
   parameter int                 DATA_W   = 8,
   parameter logic [CRC_W-1:0]   POLY_REV = 16'h8408,
   parameter upd_style_e         STYLE    = UPD_SERIAL
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic [CRC_W-1:0]  crc_out
);

   // One byte folded in, bit 0 first, reflected polynomial
   function automatic logic [CRC_W-1:0] ser_upd(input logic [CRC_W-1:0] c,
                                                 input logic [DATA_W-1:0] d);
      logic [CRC_W-1:0] r;
      logic             fb;
      r = c;
      for (int b = 0; b < DATA_W; b++) begin
         fb = r[0] ^ d[b];
         r  = r >> 1;
         if (fb) r = r ^ POLY_REV;
      end
      return r;
   endfunction

   // Which state bits feed output bit j
   function automatic logic [CRC_W-1:0] state_mask(input int j);
      logic [CRC_W-1:0] m;
      logic [CRC_W-1:0] col;
      m = '0;
      for (int i = 0; i < CRC_W; i++) begin
         col  = ser_upd({{(CRC_W-1){1'b0}}, 1'b1} << i, '0);
         m[i] = col[j];
      end
      return m;
   endfunction

   // Which data bits feed output bit j
   function automatic logic [DATA_W-1:0] data_mask(input int j);
      logic [DATA_W-1:0] m;
      logic [CRC_W-1:0]  col;
      m = '0;
      for (int i = 0; i < DATA_W; i++) begin
         col  = ser_upd('0, {{(DATA_W-1){1'b0}}, 1'b1} << i);
         m[i] = col[j];
      end
      return m;
   endfunction

   if (DATA_W < 1 || CRC_W < 2) begin : g_bad_width
      $error("crc16_lp_step: width parameters out of range");
   end
   if (POLY_REV[CRC_W-1] != 1'b1) begin : g_bad_poly
      $error("crc16_lp_step: reflected polynomial must carry the x^0 term in its top bit");
   end

   if (STYLE == UPD_SERIAL) begin : g_serial
      always_comb crc_out = ser_upd(crc_in, data_in);
   end else begin : g_matrix
      for (genvar j = 0; j < CRC_W; j++) begin : g_bit
         localparam logic [CRC_W-1:0]  SM = state_mask(j);
         localparam logic [DATA_W-1:0] DM = data_mask(j);
         assign crc_out[j] = (^(crc_in & SM)) ^ (^(data_in & DM));
      end
   end

endmodule

// File: rtl/crc16_lp_ftr_tx.sv
module crc16_lp_ftr_tx
   import crc16_lp_pkg::*;
#(
   parameter int CRC_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              end_evt,
   input  logic [CRC_W-1:0]  ref_word,
   output logic              ftr_valid,
   output logic              ftr_hi,
   output logic [DATA_W-1:0] ftr_data
);

   ftr_state_e st_q;
   ftr_state_e st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         FT_IDLE: st_d = FT_IDLE;
         FT_LOW:  st_d = FT_HIGH;
         FT_HIGH: st_d = FT_IDLE;
         default: st_d = FT_IDLE;
      endcase
      if (end_evt) st_d = FT_LOW;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= FT_IDLE;
      else        st_q <= st_d;
   end

   assign ftr_valid = (st_q != FT_IDLE);
   assign ftr_hi    = (st_q == FT_HIGH);
   assign ftr_data  = ftr_hi ? ref_word[CRC_W-1 -: DATA_W] : ref_word[DATA_W-1:0];

   // R4: low byte is followed by the high byte, then the footer ends
   a_r4_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ftr_valid && !ftr_hi && !end_evt) |=> (ftr_valid && ftr_hi));
   a_r4_high_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (ftr_hi && !end_evt) |=> !ftr_valid);
   a_r4_low_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ftr_valid) |-> !ftr_hi);

endmodule

// File: rtl/crc16_lp_chk.sv
module crc16_lp_chk #(
   parameter int CRC_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_open,
   input  logic              chk_en,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [CRC_W-1:0]  ref_word,
   output logic              chk_done,
   output logic              crc_err
);

   logic              phase_q;
   logic [DATA_W-1:0] low_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= 1'b0;
         low_q    <= '0;
         chk_done <= 1'b0;
         crc_err  <= 1'b0;
      end else begin
         chk_done <= 1'b0;
         crc_err  <= 1'b0;
         if (pkt_open) begin
            phase_q <= 1'b0;
         end else if (rx_valid) begin
            if (!phase_q) begin
               low_q   <= rx_data;
               phase_q <= 1'b1;
            end else begin
               phase_q  <= 1'b0;
               chk_done <= 1'b1;
               crc_err  <= chk_en && ({rx_data, low_q} != ref_word);
            end
         end
      end
   end

   // R8: an error pulse only when checking was on at the deciding edge
   a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |-> $past(chk_en));
   // R7: an error is always reported together with completion
   a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |-> chk_done);
   // R6: completion needs a received byte at the previous edge
   a_r6_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      chk_done |-> $past(rx_valid));

endmodule

// File: rtl/crc16_lp_top.sv
module crc16_lp_top
   import crc16_lp_pkg::*;
#(
   parameter int               DATA_W   = 8,
   parameter int               CRC_W    = 16,
   parameter logic [CRC_W-1:0] POLY_REV = 16'h8408,
   parameter logic [CRC_W-1:0] PRESET   = 16'hFFFF,
   parameter upd_style_e       STYLE    = UPD_SERIAL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic              byte_first,
   input  logic              byte_last,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              empty_pkt,
   input  logic              chk_en,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              ftr_valid,
   output logic              ftr_hi,
   output logic [DATA_W-1:0] ftr_data,
   output logic              chk_done,
   output logic              crc_err
);

   localparam int FTR_BYTES = CRC_W / DATA_W;

   if (FTR_BYTES != 2 || CRC_W % DATA_W != 0) begin : g_bad_split
      $error("crc16_lp_top: the checksum must split into exactly two footer bytes");
   end

   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_base;
   logic [CRC_W-1:0] crc_nx;
   logic [CRC_W-1:0] ref_q;
   logic             end_evt;
   logic             pkt_open;

   assign crc_base = byte_first ? PRESET : crc_q;
   assign end_evt  = (byte_valid && byte_last) || empty_pkt;
   assign pkt_open = (byte_valid && byte_first) || empty_pkt;

   crc16_lp_step #(
      .CRC_W    (CRC_W),
      .DATA_W   (DATA_W),
      .POLY_REV (POLY_REV),
      .STYLE    (STYLE)
   ) step_i (
      .crc_in  (crc_base),
      .data_in (byte_data),
      .crc_out (crc_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q <= PRESET;
         ref_q <= PRESET;
      end else begin
         if (byte_valid)     crc_q <= crc_nx;
         else if (empty_pkt) crc_q <= PRESET;
         if (end_evt)        ref_q <= byte_valid ? crc_nx : PRESET;
      end
   end

   crc16_lp_ftr_tx #(
      .CRC_W  (CRC_W),
      .DATA_W (DATA_W)
   ) ftr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .end_evt   (end_evt),
      .ref_word  (ref_q),
      .ftr_valid (ftr_valid),
      .ftr_hi    (ftr_hi),
      .ftr_data  (ftr_data)
   );

   crc16_lp_chk #(
      .CRC_W  (CRC_W),
      .DATA_W (DATA_W)
   ) chk_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .pkt_open (pkt_open),
      .chk_en   (chk_en),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .ref_word (ref_q),
      .chk_done (chk_done),
      .crc_err  (crc_err)
   );

   // R3: a zero-length payload emits the preset value, low byte first
   a_r3_empty_preset: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_pkt && !byte_valid) |=>
         (ftr_valid && !ftr_hi && ftr_data == PRESET[DATA_W-1:0]));
   // R4: the footer starts in the cycle right after a payload ends
   a_r4_footer_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
      end_evt |=> (ftr_valid && !ftr_hi));

endmodule

// File: tb/crc16_lp_top_tb_top.sv
module crc16_lp_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       byte_valid, byte_first, byte_last, empty_pkt, chk_en, rx_valid;
   logic [7:0] byte_data, rx_data;
   logic       ftr_valid, ftr_hi, chk_done, crc_err;
   logic [7:0] ftr_data;

   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   crc16_lp_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (byte_valid),
      .byte_first (byte_first),
      .byte_last  (byte_last),
      .byte_data  (byte_data),
      .empty_pkt  (empty_pkt),
      .chk_en     (chk_en),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .ftr_valid  (ftr_valid),
      .ftr_hi     (ftr_hi),
      .ftr_data   (ftr_data),
      .chk_done   (chk_done),
      .crc_err    (crc_err)
   );

   // Vector table: length, first byte, byte step, check enable, corrupt footer
   localparam int NV = 6;
   localparam int          V_LEN  [NV] = '{9, 1, 2, 16, 300, 5};
   localparam logic [7:0]  V_ST   [NV] = '{8'h31, 8'h00, 8'hA5, 8'h10, 8'h7E, 8'h55};
   localparam logic [7:0]  V_STEP [NV] = '{8'h01, 8'h00, 8'h03, 8'h11, 8'h01, 8'h00};
   localparam bit          V_CHK  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
   localparam bit          V_BAD  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

   function automatic logic [15:0] model_crc(input int len, input logic [7:0] st,
                                             input logic [7:0] stp);
      logic [15:0] c;
      logic [7:0]  d;
      logic        fb;
      c = 16'hFFFF;
      for (int i = 0; i < len; i++) begin
         d = 8'(st + i * stp);
         for (int b = 0; b < 8; b++) begin
            fb = c[0] ^ d[b];
            c  = c >> 1;
            if (fb) c = c ^ 16'h8408;
         end
      end
      return c;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      byte_valid = 0; byte_first = 0; byte_last = 0; byte_data = 8'h00;
      empty_pkt = 0; rx_valid = 0; rx_data = 8'h00;
   endtask

   // Sends the payload; returns at the negedge after the last byte's edge
   task automatic send_pay(input int len, input logic [7:0] st, input logic [7:0] stp,
                           input bit gap);
      for (int i = 0; i < len; i++) begin
         if (gap && i == len / 2) begin
            @(negedge clk);
            byte_valid = 0; byte_first = 1; byte_last = 1; byte_data = 8'hC3;
         end
         @(negedge clk);
         byte_valid = 1;
         byte_first = (i == 0);
         byte_last  = (i == len - 1);
         byte_data  = 8'(st + i * stp);
      end
      @(negedge clk);
      idle_inputs();
   endtask

   // Checks both footer bytes, starting at the current negedge
   task automatic check_footer(input string req, input logic [15:0] exp);
      check({req, " low byte valid"}, {ftr_valid, ftr_hi}, 2'b10);
      check({req, " low byte"}, ftr_data, exp[7:0]);
      @(negedge clk);
      check({req, " high byte valid"}, {ftr_valid, ftr_hi}, 2'b11);
      check({req, " high byte"}, ftr_data, exp[15:8]);
      @(negedge clk);
      check({req, " footer ended"}, ftr_valid, 0);
   endtask

   task automatic send_rx(input logic [15:0] w, input bit exp_err, input string req);
      rx_valid = 1; rx_data = w[7:0];
      @(negedge clk);
      rx_data = w[15:8];
      @(negedge clk);
      rx_valid = 0;
      check({req, " chk_done"}, chk_done, 1);
      check({req, " crc_err"}, crc_err, exp_err);
   endtask

   initial begin
      #(8 * 20000);
      if (!finished) begin
         nerr++;
         $display("FAIL watchdog: run hung, actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      logic [15:0] exp;
      idle_inputs();
      chk_en = 1;
      rst_n  = 0;
      repeat (3) @(negedge clk);
      // R9: outputs quiet in reset
      check("R9 reset ftr_valid", ftr_valid, 0);
      check("R9 reset chk_done", chk_done, 0);
      check("R9 reset crc_err", crc_err, 0);
      rst_n = 1;
      @(negedge clk);
      check("R9 after reset outputs", {ftr_valid, chk_done, crc_err}, 0);

      // R1: known reference value, independent of the model
      check("R1 model sanity 123456789", model_crc(9, 8'h31, 8'h01), 16'h6F91);

      // Table walk: R1, R2 (preset per payload), R4, R6, R7, R8, R10
      for (int v = 0; v < NV; v++) begin
         logic [15:0] ftr;
         exp = model_crc(V_LEN[v], V_ST[v], V_STEP[v]);
         chk_en = V_CHK[v];
         send_pay(V_LEN[v], V_ST[v], V_STEP[v], 1'b0);
         check_footer($sformatf("R1 R2 R4 R10 vector %0d", v), exp);
         if (v == 0) check("R1 footer 123456789", exp, 16'h6F91);
         ftr = V_BAD[v] ? (V_CHK[v] ? (exp ^ 16'h0100) : 16'h0000) : exp;
         send_rx(ftr, V_CHK[v] && V_BAD[v],
                 V_CHK[v] ? (V_BAD[v] ? "R7 mismatch" : "R6 match") : "R8 check off");
      end

      // R3: zero-length payload
      chk_en = 1;
      @(negedge clk);
      empty_pkt = 1;
      @(negedge clk);
      empty_pkt = 0;
      check_footer("R3 empty payload", 16'hFFFF);
      send_rx(16'hFFFF, 1'b0, "R3 R6 empty footer match");

      // R8: disabled check with zero footer from a non-computing peer
      chk_en = 0;
      send_pay(7, 8'h20, 8'h05, 1'b0);
      check_footer("R8 payload", model_crc(7, 8'h20, 8'h05));
      send_rx(16'h0000, 1'b0, "R8 zero footer ignored");
      chk_en = 1;

      // R5: strobes without byte_valid inside a payload change nothing
      send_pay(12, 8'h9C, 8'h07, 1'b1);
      check_footer("R5 gap cycle", model_crc(12, 8'h9C, 8'h07));
      send_rx(model_crc(12, 8'h9C, 8'h07), 1'b0, "R5 gap footer match");

      // R11: stray single footer byte is discarded at payload start
      rx_valid = 1; rx_data = 8'h5A;
      @(negedge clk);
      rx_valid = 0;
      @(negedge clk);
      check("R11 no done after stray byte", chk_done, 0);
      send_pay(4, 8'h61, 8'h01, 1'b0);
      exp = model_crc(4, 8'h61, 8'h01);
      check_footer("R11 payload", exp);
      send_rx(exp, 1'b0, "R11 realigned footer");

      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule